// File: doc/BRIEF.md
# MDIO Station-Management Master

This block runs single-register transactions against an external PHY over the two-wire management interface: a clock output (MDC) and a bidirectional data line (MDIO). Software first loads a 16-bit data register when it wants a write. It then writes a command word that holds a PHY address, a register address, a write-select bit, a clock-range code and a go bit. Setting go raises a busy flag. The block sends a clause-22 frame and turns the data line around when the command is a read. When the frame ends, hardware drops busy. For a read, the captured word is then in the same data register.

MDC comes from the system clock through a divider. The divide ratio is picked from a short clock-range code matched to the system clock frequency, so software never programs the divisor itself. MDIO is split into an output, an output enable and an input, and the tri-state buffer sits at the chip top level.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy, mdc, mdio_oe, data_rd and clk_range are all 0.
- R2: While idle, a data_we pulse loads data_wr into the data register, and data_rd shows the new value on the next cycle.
- R3: A command write with cmd_go=1 while idle sets busy on the next cycle. Busy returns to 0 at the falling MDC edge that ends the 64th MDC period, which is half a divide ratio after the last rising MDC edge.
- R4: For a write (cmd_write=1), the 64 bits sampled on rising MDC edges, in order, are 32 ones, 0,1, opcode 0,1, the 5-bit PHY address, the 5-bit register address, 1,0, and then the 16 data-register bits. Every field is sent MSB first, and mdio_oe stays 1 for all 64 bits.
- R5: For a read (cmd_write=0), the bits before the turnaround are the same as in R4 except that the opcode is 1,0. mdio_oe is 0 from bit 46 (the first turnaround bit) through bit 63. The mdio_i values sampled at the rising MDC edges of bits 48 to 63, MSB first, appear on data_rd once busy has cleared.
- R6: The clock-range code sets the MDC period in system clocks: code 0 gives 16, code 1 gives 26, code 2 gives 42, code 3 gives 62, and code 4 gives 102. Codes 5 to 7 also give 102.
- R7: While busy, command writes and data writes are ignored. The frame on the wire, clk_range and (for writes) data_rd keep their original values.
- R8: A command write with cmd_go=0 while idle updates clk_range. It starts no transaction: busy and mdc stay 0. The range code stays in force for later commands.
- R9: mdio_o changes only while MDC is low. It is stable at every rising MDC edge.
- R10: While idle, mdc and mdio_oe are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_go | input | 1 | Busy/go bit of the command word |
| cmd_write | input | 1 | 1 selects a write, 0 selects a read |
| cmd_phy | input | 5 | PHY address field |
| cmd_reg | input | 5 | PHY register address field |
| cmd_range | input | 3 | Clock-range code |
| data_we | input | 1 | Data register write strobe |
| data_wr | input | 16 | Data register write value |
| busy | output | 1 | Transaction in progress |
| data_rd | output | 16 | Data register contents (write data or read result) |
| clk_range | output | 3 | Clock-range code in force |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A wrong bit counter or shift register shows up as a misplaced field in the sampled frame. It can also show up as mdio_oe dropping at the wrong bit, or as busy clearing early or late, all within the transaction in progress. A wrong divider state shows up within one MDC period as a period mismatch, at most 102 system clocks. Command-latching faults under a busy condition show up after completion, as a changed clock range, a changed frame or changed write data.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int RANGE_W   = 3;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
  localparam int BIT_W     = $clog2(FRAME_LEN);
  localparam int CNT_W     = 7;
  localparam int TA_IDX    = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int DATA_IDX  = TA_IDX + 2;

  // Divide ratio (system clocks per MDC period) for a clock-range code
  function automatic logic [CNT_W-1:0] div_ratio(input logic [RANGE_W-1:0] code);
    case (code)
      3'd0:    return CNT_W'(16);
      3'd1:    return CNT_W'(26);
      3'd2:    return CNT_W'(42);
      3'd3:    return CNT_W'(62);
      default: return CNT_W'(102);
    endcase
  endfunction

  // Full management frame, first bit on the wire in the MSB
  function automatic logic [FRAME_LEN-1:0] build_frame(input logic rd,
                                                       input logic [ADDR_W-1:0] phy,
                                                       input logic [ADDR_W-1:0] ra,
                                                       input logic [DATA_W-1:0] wdat);
    return {{PRE_LEN{1'b1}}, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10, wdat};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [RANGE_W-1:0] range_code,
  output logic               mdc,
  output logic               rise_evt,
  output logic               fall_evt
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ratio;
  logic [CNT_W-1:0] half;

  assign ratio    = div_ratio(range_code);
  assign half     = ratio >> 1;
  assign rise_evt = en && (cnt == half - 1'b1);
  assign fall_evt = en && (cnt == ratio - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= fall_evt ? '0 : cnt + 1'b1;
      if (rise_evt)      mdc <= 1'b1;
      else if (fall_evt) mdc <= 1'b0;
    end
  end

  // Divider counter never leaves its period
  assert_cnt_in_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < ratio);
  // A falling MDC edge always starts a new period
  assert_fall_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en && $fell(mdc) |-> cnt == '0);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 start_rd,
  input  logic [FRAME_LEN-1:0] frame_in,
  input  logic                 rise_evt,
  input  logic                 fall_evt,
  input  logic                 mdio_i,
  output logic                 active,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 done,
  output logic [DATA_W-1:0]    rd_data
);
  localparam logic [BIT_W-1:0] LAST_POS = BIT_W'(FRAME_LEN - 1);
  localparam logic [BIT_W-1:0] TA_POS   = BIT_W'(TA_IDX);
  localparam logic [BIT_W-1:0] DATA_POS = BIT_W'(DATA_IDX);

  logic                 is_read;
  logic [FRAME_LEN-1:0] shreg;
  logic [BIT_W-1:0]     bit_idx;
  logic [BIT_W-1:0]     nxt_idx;
  logic                 sample_evt;
  logic                 shift_evt;

  assign nxt_idx    = bit_idx + 1'b1;
  assign done       = active && fall_evt && (bit_idx == LAST_POS);
  assign shift_evt  = active && fall_evt && (bit_idx != LAST_POS);
  assign sample_evt = active && rise_evt && is_read && (bit_idx >= DATA_POS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      is_read <= 1'b0;
      shreg   <= '0;
      bit_idx <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      rd_data <= '0;
    end else if (start) begin
      active  <= 1'b1;
      is_read <= start_rd;
      shreg   <= frame_in << 1;
      bit_idx <= '0;
      mdio_o  <= frame_in[FRAME_LEN-1];
      mdio_oe <= 1'b1;
    end else begin
      if (sample_evt) rd_data <= {rd_data[DATA_W-2:0], mdio_i};
      if (shift_evt) begin
        bit_idx <= nxt_idx;
        mdio_o  <= shreg[FRAME_LEN-1];
        shreg   <= shreg << 1;
        mdio_oe <= !(is_read && (nxt_idx >= TA_POS));
      end
      if (done) begin
        active  <= 1'b0;
        mdio_oe <= 1'b0;
      end
    end
  end

  // Read frames release the line from the turnaround onward
  assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    active && is_read && (bit_idx >= TA_POS) |-> !mdio_oe);
  // Write frames keep driving for the whole frame
  assert_write_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active && !is_read |-> mdio_oe);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic        cmd_go,
  input  logic        cmd_write,
  input  logic [4:0]  cmd_phy,
  input  logic [4:0]  cmd_reg,
  input  logic [2:0]  cmd_range,
  input  logic        data_we,
  input  logic [15:0] data_wr,
  output logic        busy,
  output logic [15:0] data_rd,
  output logic [2:0]  clk_range,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic                 accept;
  logic                 start;
  logic                 rd_q;
  logic                 eng_active;
  logic                 eng_done;
  logic                 rise_evt;
  logic                 fall_evt;
  logic [DATA_W-1:0]    eng_rd;
  logic [FRAME_LEN-1:0] frame;

  assign accept = cmd_we && !busy;
  assign start  = accept && cmd_go;
  assign frame  = build_frame(!cmd_write, cmd_phy, cmd_reg, data_rd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      rd_q      <= 1'b0;
      clk_range <= '0;
      data_rd   <= '0;
    end else begin
      if (accept) clk_range <= cmd_range;
      if (start) begin
        busy <= 1'b1;
        rd_q <= !cmd_write;
      end else if (eng_done) begin
        busy <= 1'b0;
      end
      if (eng_done && rd_q)        data_rd <= eng_rd;
      else if (data_we && !busy)   data_rd <= data_wr;
    end
  end

  mdio_mdc_gen u_mdc (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (busy),
    .range_code (clk_range),
    .mdc        (mdc),
    .rise_evt   (rise_evt),
    .fall_evt   (fall_evt)
  );

  mdio_frame_engine u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .start_rd (!cmd_write),
    .frame_in (frame),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .mdio_i   (mdio_i),
    .active   (eng_active),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .done     (eng_done),
    .rd_data  (eng_rd)
  );

  assert_busy_tracks_engine_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy == eng_active);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc && !mdio_oe);
  assert_stable_at_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $rose(mdc) |-> $stable(mdio_o));
  assert_busy_ignores_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_we |=> $stable(clk_range));
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0, cmd_go = 1'b0, cmd_write = 1'b0;
  logic [4:0]  cmd_phy = '0, cmd_reg = '0;
  logic [2:0]  cmd_range = '0;
  logic        data_we = 1'b0;
  logic [15:0] data_wr = '0;
  logic        busy, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b0;
  logic [15:0] data_rd;
  logic [2:0]  clk_range;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mdio_master uut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_go(cmd_go), .cmd_write(cmd_write),
    .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_range(cmd_range), .data_we(data_we),
    .data_wr(data_wr), .busy(busy), .data_rd(data_rd), .clk_range(clk_range),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_ratio(input logic [2:0] c);
    int r;
    if (c > 3'd3) r = 102;
    else if (c[1]) r = c[0] ? 62 : 42;
    else r = c[0] ? 26 : 16;
    return r;
  endfunction

  function automatic logic [63:0] exp_frame(input bit wr, input logic [4:0] phy,
                                            input logic [4:0] ra, input logic [15:0] d);
    logic [63:0] f = '1;
    f[31] = 1'b0; f[30] = 1'b1;
    f[29] = !wr;  f[28] = wr;
    for (int i = 0; i < 5; i++) begin
      f[27 - i] = phy[4 - i];
      f[22 - i] = ra[4 - i];
    end
    f[17] = 1'b1; f[16] = 1'b0;
    for (int i = 0; i < 16; i++) f[15 - i] = d[15 - i];
    return f;
  endfunction

  task automatic do_cmd(input bit go, input bit wr, input logic [4:0] phy,
                        input logic [4:0] ra, input logic [2:0] rng);
    @(negedge clk);
    cmd_we = 1'b1; cmd_go = go; cmd_write = wr; cmd_phy = phy; cmd_reg = ra; cmd_range = rng;
    @(negedge clk);
    cmd_we = 1'b0; cmd_go = 1'b0;
  endtask

  task automatic do_data(input logic [15:0] v);
    @(negedge clk);
    data_we = 1'b1; data_wr = v;
    @(negedge clk);
    data_we = 1'b0;
  endtask

  task automatic run_txn(input bit wr, input logic [4:0] phy, input logic [4:0] ra,
                         input logic [2:0] rng, input logic [15:0] wdata,
                         input logic [15:0] rdval, input bit interfere);
    logic [63:0] got, expf, mask;
    logic [63:0] oes;
    time t0;
    int per, n;
    got = '0; oes = '0; per = 0; t0 = 0;
    if (wr) do_data(wdata);
    mdio_i = 1'b0;
    do_cmd(1'b1, wr, phy, ra, rng);
    check(busy === 1'b1, "R3 busy after go", {63'd0, busy}, 64'd1);
    for (int k = 0; k < 64; k++) begin
      @(posedge mdc);
      #1;
      got[63 - k] = mdio_o;
      oes[k] = mdio_oe;
      if (k == 0) t0 = $time;
      if (k == 1) per = int'(($time - t0) / 4);
      if (k + 1 >= 48 && k + 1 <= 63) mdio_i = rdval[63 - (k + 1)];
      if (interfere && k == 5) begin
        do_cmd(1'b1, !wr, phy ^ 5'd1, ra ^ 5'd1, rng + 3'd1);
        do_data(~wdata);
      end
    end
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (busy === 1'b1 && n < 300);
    check(n == exp_ratio(rng) / 2 + 1, "R3 busy clear time", 64'(n), 64'(exp_ratio(rng) / 2 + 1));
    check(per == exp_ratio(rng), "R6 mdc period", 64'(per), 64'(exp_ratio(rng)));
    expf = exp_frame(wr, phy, ra, wdata);
    mask = wr ? '1 : {{46{1'b1}}, 18'd0};
    check((got & mask) == (expf & mask), wr ? "R4 write frame" : "R5 read frame",
          got & mask, expf & mask);
    check(oes == (wr ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_3FFF_FFFF_FFFF),
          wr ? "R4 oe pattern" : "R5 oe release", oes,
          wr ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_3FFF_FFFF_FFFF);
    check(data_rd === (wr ? wdata : rdval), wr ? "R2 R7 data kept" : "R5 read data",
          64'(data_rd), 64'(wr ? wdata : rdval));
    check(clk_range === rng, "R7 R8 range kept", 64'(clk_range), 64'(rng));
    check(mdc === 1'b0 && mdio_oe === 1'b0, "R10 idle quiet", {62'd0, mdc, mdio_oe}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 0 && mdc === 0 && mdio_oe === 0 && data_rd === 0 && clk_range === 0,
          "R1 reset state", {43'd0, busy, mdc, mdio_oe, data_rd, clk_range}, 64'd0);
    // R8: range-only command
    do_cmd(1'b0, 1'b1, 5'd3, 5'd4, 3'd3);
    repeat (40) @(negedge clk);
    check(clk_range === 3'd3, "R8 range set", 64'(clk_range), 64'd3);
    check(busy === 0 && mdc === 0, "R8 no start", {62'd0, busy, mdc}, 64'd0);
    // R2: idle data write
    do_data(16'hA5C3);
    check(data_rd === 16'hA5C3, "R2 data load", 64'(data_rd), 64'hA5C3);
    // Directed corners
    run_txn(1'b1, 5'd0, 5'd31, 3'd0, 16'h0000, 16'h0000, 1'b0);
    run_txn(1'b0, 5'd31, 5'd0, 3'd4, 16'h0000, 16'hFFFF, 1'b0);
    run_txn(1'b0, 5'd17, 5'd10, 3'd5, 16'h0000, 16'h8001, 1'b0);
    run_txn(1'b1, 5'd21, 5'd10, 3'd7, 16'hFFFF, 16'h0000, 1'b1);
    run_txn(1'b0, 5'd9, 5'd2, 3'd1, 16'h0000, 16'h5A5A, 1'b1);
    // Random mix
    for (int t = 0; t < 10; t++) begin
      run_txn(1'($urandom), 5'($urandom), 5'($urandom), 3'($urandom % 4),
              16'($urandom), 16'($urandom), (t % 3) == 0);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule